// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block controls an 8-bit conversion that runs in two steps and uses one bank of 15 comparators for both. When a conversion is requested, the sequencer captures the comparator bank's thermometer output and turns it into a 4-bit upper half. That value goes to a residue DAC. The sequencer then waits for the DAC to settle, either for a programmed number of cycles or until a settled flag arrives. It then reads the same comparator bank a second time. In the second read the bank compares the residue (the input minus the DAC level), and the result is the 4-bit lower half.

The ladder, the comparators, the DAC and the residue path are analog and sit outside this block. The sequencer only sees their digital side: a 15-bit thermometer vector in, a settled flag in, and a 4-bit DAC code out. A single encoder sits behind the comparator bank. Its output is steered into either the upper or the lower half of the result, depending on the phase.

Top module: `hf_conv_seq`

## Requirements
- R1: After a synchronous reset, busy and done are low, and the result and the DAC code are both zero.
- R2: The encoder maps a clean thermometer code with k low-order ones to the value k (0 to 15). If the code has bubbles, the encoder uses the highest asserted bit: a highest set bit at index i gives the value i+1.
- R3: The first comparator sample after an accepted start becomes the upper 4 bits. The DAC code output shows this value from the cycle after the capture until the next conversion's first capture.
- R4: The second comparator sample becomes the lower 4 bits. The result is {upper, lower}, with the upper half in bits 7:4.
- R5: The settle phase lasts settle_cycles_i cycles, with a minimum of 1. It ends early, after one cycle, if dac_settled_i is high during that cycle. Busy therefore stays high for exactly 2 + S cycles, where S is the settle length.
- R6: Busy rises in the cycle after a start is accepted, stays high through the fine sample, and is low while done is high.
- R7: A start is accepted only when the sequencer is idle. A start in any other cycle, including the cycle in which done is high, has no effect.
- R8: Done is high for exactly one cycle. The result changes only as done rises and holds its value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request strobe |
| cmp_i | input | 15 | Thermometer output of the comparator bank |
| dac_settled_i | input | 1 | Residue DAC has settled |
| settle_cycles_i | input | 8 | Maximum settle length in cycles; hold stable during a conversion |
| dac_code_o | output | 4 | Upper half driven to the residue DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Registered 8-bit result |

## Verification
Two events can fall in the same cycle: the one-cycle done pulse and a fresh start request. The bench raises start exactly in the done cycle, and also in the middle of the settle phase. It then checks that busy stays low after done, that no extra done pulse appears, and that the busy length of the current conversion does not change. A scoreboard predicts each conversion's result and busy length from a digital model of the input, and the monitor compares them when done rises. Other tests cover bubble codes, both extremes of the input range, and the two ways the settle phase can end.

// File: rtl/hf_pkg.sv
package hf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COARSE = 3'd1,
        ST_SETTLE = 3'd2,
        ST_FINE   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cap_coarse;
        logic cap_fine;
        logic settle_run;
        logic busy;
        logic done;
    } seq_ctl_t;

    function automatic seq_ctl_t decode_state(input seq_state_e st);
        seq_ctl_t c;
        c = '0;
        unique case (st)
            ST_COARSE: begin c.cap_coarse = 1'b1; c.busy = 1'b1; end
            ST_SETTLE: begin c.settle_run = 1'b1; c.busy = 1'b1; end
            ST_FINE:   begin c.cap_fine   = 1'b1; c.busy = 1'b1; end
            ST_DONE:   c.done = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
    parameter int SEG_W = 4,
    localparam int CMP_N = (1 << SEG_W) - 1
) (
    input  logic [CMP_N-1:0] therm_i,
    output logic [SEG_W-1:0] code_o
);

    // Highest asserted position wins; this absorbs bubbles in the code.
    logic [SEG_W-1:0] lvl [CMP_N+1];

    assign lvl[0] = '0;

    generate
        for (genvar g = 0; g < CMP_N; g++) begin : g_pos
            assign lvl[g+1] = therm_i[g] ? SEG_W'(g + 1) : lvl[g];
        end
    endgenerate

    assign code_o = lvl[CMP_N];

    // R2: for a clean thermometer code the value equals the number of ones
    always_comb begin
        if ((therm_i & (therm_i + 1'b1)) == '0) begin
            a_r2_monotonic_count: assert (32'(code_o) == $countones(therm_i));
        end
    end

endmodule

// File: rtl/hf_settle_timer.sv
module hf_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             settled_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (settled_i || (cnt_next >= {1'b0, limit_i}));

    // R5: the counter never passes the programmed limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (run_i && limit_i != '0) |-> (cnt_q < limit_i));

    // R5: a settled flag ends the phase at this edge
    a_r5_settled_exit: assert property (@(posedge clk) disable iff (rst)
        (run_i && settled_i) |-> expire_o);

endmodule

// File: rtl/hf_seq_fsm.sv
module hf_seq_fsm
    import hf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       expire_i,
    output seq_state_e state_o,
    output seq_ctl_t   ctl_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)  state_d = ST_COARSE;
            ST_COARSE: state_d = ST_SETTLE;
            ST_SETTLE: if (expire_i) state_d = ST_FINE;
            ST_FINE:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign ctl_o   = decode_state(state_q);

    // R7: a start seen while idle always launches a conversion
    a_r7_start_accept: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_COARSE));

    // R7: the done cycle never chains into a new conversion
    a_r7_done_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R6: the coarse capture is always followed by the settle phase
    a_r6_coarse_to_settle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COARSE) |=> (state_q == ST_SETTLE));

endmodule

// File: rtl/hf_conv_seq.sv
module hf_conv_seq
    import hf_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int CNT_W = 8,
    localparam int CMP_N = (1 << SEG_W) - 1,
    localparam int RES_W = 2 * SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CMP_N-1:0] cmp_i,
    input  logic             dac_settled_i,
    input  logic [CNT_W-1:0] settle_cycles_i,
    output logic [SEG_W-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    seq_state_e       state;
    seq_ctl_t         ctl;
    logic             expire;
    logic [SEG_W-1:0] enc_code;
    logic [SEG_W-1:0] coarse_q;
    logic [RES_W-1:0] result_q;

    hf_therm_enc #(.SEG_W(SEG_W)) u_enc (
        .therm_i (cmp_i),
        .code_o  (enc_code)
    );

    hf_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctl.settle_run),
        .settled_i (dac_settled_i),
        .limit_i   (settle_cycles_i),
        .expire_o  (expire)
    );

    hf_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .expire_i (expire),
        .state_o  (state),
        .ctl_o    (ctl)
    );

    // One encoder, two destinations: the phase picks which half is loaded.
    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
            result_q <= '0;
        end else begin
            if (ctl.cap_coarse) coarse_q <= enc_code;
            if (ctl.cap_fine)   result_q <= {coarse_q, enc_code};
        end
    end

    assign dac_code_o = coarse_q;
    assign result_o   = result_q;
    assign busy_o     = ctl.busy;
    assign done_o     = ctl.done;

    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: the result only moves when done rises
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);

    // R6: busy and done never overlap
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R3: the DAC code is frozen outside the coarse capture
    a_r3_dac_stable: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COARSE) |=> $stable(dac_code_o));

    // R4: the upper half of a fresh result matches the DAC code
    a_r4_upper_half: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (result_o[RES_W-1:SEG_W] == dac_code_o));

endmodule

// File: tb/sim_hf_conv_seq.sv
`timescale 1ns/1ps
module sim_hf_conv_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [14:0] cmp_i;
    logic        dac_settled_i;
    logic [7:0]  settle_cycles_i;
    logic [3:0]  dac_code_o;
    logic        busy_o;
    logic        done_o;
    logic [7:0]  result_o;

    typedef struct {
        logic [7:0] res;
        int         busy_len;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   n_done  = 0;
    int   n_conv  = 0;
    int   busy_cnt = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    hf_conv_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
        .dac_settled_i(dac_settled_i), .settle_cycles_i(settle_cycles_i),
        .dac_code_o(dac_code_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [14:0] therm(input int n);
        return 15'((1 << n) - 1);
    endfunction

    function automatic int clamp15(input int v);
        if (v < 0)  return 0;
        if (v > 15) return 15;
        return v;
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard as each conversion completes
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) busy_cnt++;
            if (done_o) begin
                n_done++;
                if (q.size() == 0) begin
                    check(0, "R7 unexpected done", n_done, n_conv);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(result_o == e.res, "R4 result", result_o, e.res);
                    check(dac_code_o == e.res[7:4], "R3 dac code", dac_code_o, e.res[7:4]);
                    check(busy_cnt == e.busy_len, "R5 busy length", busy_cnt, e.busy_len);
                    check(!busy_o, "R6 busy low at done", busy_o, 0);
                end
                busy_cnt = 0;
            end
        end
    end

    // Driver: one conversion with the analog front end modelled digitally
    task automatic conv(input int vin, input int settle_n, input bit settled,
                        input bit bubble, input bit start_busy, input bit start_done);
        exp_t e;
        int   c, f, r;
        c = bubble ? 10 : (vin >> 4);
        f = clamp15(vin - 16 * c);
        e.res = 8'((c << 4) | f);
        e.busy_len = 2 + ((settled || settle_n == 0) ? 1 : settle_n);
        @(negedge clk);
        settle_cycles_i = 8'(settle_n);
        dac_settled_i   = settled;
        cmp_i   = bubble ? 15'b000_0010_0011_1111 : therm(vin >> 4);
        start_i = 1'b1;
        q.push_back(e);
        n_conv++;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        r = clamp15(vin - 16 * int'(dac_code_o));
        cmp_i = therm(r);
        if (start_busy) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        if (start_done) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R8 done single cycle", done_o, 0);
        check(!busy_o, "R7 start ignored", busy_o, 0);
        @(negedge clk);
        check(!busy_o && !done_o, "R7 still idle", busy_o, 0);
        repeat (2) @(negedge clk);
        check(result_o == e.res, "R8 result held", result_o, e.res);
    endtask

    initial begin
        #2_000_000;
        check(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        cmp_i = '0;
        dac_settled_i = 1'b0;
        settle_cycles_i = 8'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o, "R1 control idle", {busy_o, done_o}, 0);
        check(result_o == 8'h00, "R1 result zero", result_o, 0);
        check(dac_code_o == 4'h0, "R1 dac zero", dac_code_o, 0);

        conv(8'h00, 3, 0, 0, 0, 0);    // R3 R4 lowest input
        conv(8'hFF, 3, 0, 0, 0, 0);    // R4 top of range
        conv(8'h80, 5, 0, 0, 0, 0);    // R5 counted settle
        conv(8'h7F, 5, 1, 0, 0, 0);    // R5 early settled exit
        conv(8'h3C, 0, 0, 0, 0, 0);    // R5 zero limit gives one cycle
        conv(8'h6A, 2, 0, 1, 0, 0);    // R2 bubble code
        conv(8'hA5, 4, 0, 0, 1, 0);    // R7 start during settle
        conv(8'h5E, 3, 0, 0, 0, 1);    // R7 start in done cycle
        conv(8'h11, 1, 0, 0, 1, 1);    // R7 both
        for (int v = 7; v < 256; v += 37) conv(v, 2, 0, 0, 0, 0);

        repeat (4) @(negedge clk);
        check(n_done == n_conv, "R8 one done per conversion", n_done, n_conv);
        check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
        finish_up();
    end

endmodule